// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Registers

This block is the software-visible configuration space of a DRAM controller. It is a bank of 32-bit words reached over a simple single-cycle, word-addressed request port that spans a 4 KiB window of 1024 words. Word 0 is a lock register. The value written to it is compared with two magic keys. The first key opens the bank and the second seals it until the next reset. Any other value closes the bank again so that it can be reopened later. While the bank is closed, writes to guarded words are dropped. A fixed set of eight words is exempt from the lock and always takes writes.

Some words alter the data as it is stored. The configuration word keeps its version, aperture and size fields forced and its reserved bits cleared. The PHY status word can never report busy and always reports PLL lock. The ECC self-test control word always reports that the test finished without failure. The installed memory size is a parameter, and its two-bit code is placed in the configuration word at reset and on every write. A one-cycle `blk_err` pulse marks each write that the lock rejects.

Top module: `dcfg_regbank`

## Requirements
- R1: After synchronous reset the lock word reads 0x00000000 and the configuration word (word 1) reads 0x3000000C OR the size code. The size code is 0, 1, 2 or 3 for MEM_MIB = 256, 512, 1024 or 2048, so the default reads 0x3000000E. The PHY words read as follows: word 0x100 is 0x2, word 0x114 is 0x0FFFFFFF, and words 0x11A and 0x11F are 0xFF. Every other word reads 0. Reset takes priority over a write in the same cycle.
- R2: Writing 0xFC600309 to word 0 opens the bank, so word 0 reads 0x01 and guarded writes take effect. The bank only opens through that key.
- R3: Writing 0xDEADDEAD to word 0 seals the bank, which then reads 0x10. Any value other than the two keys closes the bank softly, which then reads 0x00.
- R4: While the bank is soft-closed, writes to guarded words leave them unchanged, but word 0 still accepts keys.
- R5: While the bank is sealed, every guarded write is dropped, including writes to word 0, and the seal lasts until reset.
- R6: Words 0x14, 0x1B, 0x1D, 0x1E, 0x1F, 0x22, 0x23 and 0x2D take writes in every lock state.
- R7: A write of D to word 1 stores (D AND 0x0FF03FB0) OR 0x3000000C OR the size code. Bits 31:28 always hold 3 and bits 3:2 always hold 0b11.
- R8: A write of D to word 0x18 stores D with bit 0 cleared and bit 4 set.
- R9: A write of D to word 0x1C stores D with bit 12 set and bit 13 cleared.
- R10: Only accesses with all four byte enables set take effect. A partial write is ignored and a partial read returns 0. Words outside 0x000–0x03F and 0x100–0x11F read 0 and ignore writes.
- R11: `blk_err` is high for exactly the cycle after each write that the lock rejects, and it stays low after accepted or exempt writes.
- R12: Read data is registered. `rdata` changes on the clock edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address within the 4 KiB window |
| be | input | 4 | Byte enables; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| blk_err | output | 1 | One-cycle pulse for a write rejected by the lock |

## Verification
Two things can happen in the same cycle. The lock decision for a write is made from the lock state held before the edge, while a key written to word 0 changes that same state at that edge. The bench therefore sends a sealing key and then an opening key straight after it, and expects the second one to be refused and flagged. Reset and a write can also land on the same edge. The bench asserts reset together with a guarded write and checks that the word reads back its reset value and that the lock is closed.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [31:0] KEY_SEAL = 32'hDEAD_DEAD;

  typedef enum logic [1:0] {
    LK_SOFT = 2'd0,
    LK_OPEN = 2'd1,
    LK_HARD = 2'd2
  } lock_e;

  localparam logic [31:0] RD_SOFT = 32'h0000_0000;
  localparam logic [31:0] RD_OPEN = 32'h0000_0001;
  localparam logic [31:0] RD_HARD = 32'h0000_0010;

  localparam int W_PROT = 0;
  localparam int W_CONF = 1;
  localparam int W_STAT = 'h18;
  localparam int W_ECC  = 'h1C;

  localparam logic [31:0] CONF_KEEP  = 32'h0FF0_3FB0;
  localparam logic [31:0] CONF_FIXED = 32'h3000_000C;

  function automatic logic [1:0] size_code(input int unsigned mib);
    case (mib)
      256:     return 2'd0;
      512:     return 2'd1;
      1024:    return 2'd2;
      2048:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_exempt(input logic [11:0] w);
    case (w)
      12'h14, 12'h1B, 12'h1D, 12'h1E,
      12'h1F, 12'h22, 12'h23, 12'h2D: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] phy_reset(input int i);
    case (i)
      'h00:    return 32'h0000_0002;
      'h14:    return 32'h0FFF_FFFF;
      'h1A:    return 32'h0000_00FF;
      'h1F:    return 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/dcfg_lock.sv
module dcfg_lock
  import dcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic [31:0] key_data,
  output lock_e       state_o,
  output logic [31:0] prot_rd
);
  lock_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_SOFT;
    end else if (key_we && state_q != LK_HARD) begin
      if (key_data == KEY_OPEN)      state_q <= LK_OPEN;
      else if (key_data == KEY_SEAL) state_q <= LK_HARD;
      else                           state_q <= LK_SOFT;
    end
  end

  always_comb begin
    case (state_q)
      LK_OPEN: prot_rd = RD_OPEN;
      LK_HARD: prot_rd = RD_HARD;
      default: prot_rd = RD_SOFT;
    endcase
  end

  assign state_o = state_q;

  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_HARD) |=> (state_q == LK_HARD)); // R5
  AST_OPEN_BY_KEY: assert property (@(posedge clk) disable iff (rst)
    (state_q != LK_OPEN) |=> (state_q != LK_OPEN || $past(key_we && key_data == KEY_OPEN))); // R2
endmodule

// File: rtl/dcfg_wfilter.sv
module dcfg_wfilter
  import dcfg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [1:0] SIZE_CODE = 2'd2
) (
  input  logic              req,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  lock_e             state,
  output logic              wr_en,
  output logic              key_we,
  output logic [31:0]       wr_data,
  output logic              blocked
);
  logic fire, is_prot, exempt, gate;

  always_comb begin
    fire    = req && we && (be == 4'hF);
    is_prot = (addr == ADDR_W'(W_PROT));
    exempt  = is_exempt(12'(addr));
    gate    = (state == LK_HARD) || (state == LK_SOFT && !is_prot);
    blocked = fire && !exempt && gate;
    key_we  = fire && is_prot && !blocked;
    wr_en   = fire && !is_prot && !blocked;

    wr_data = wdata;
    if (addr == ADDR_W'(W_CONF)) begin
      wr_data = (wdata & CONF_KEEP) | CONF_FIXED | {30'b0, SIZE_CODE};
    end else if (addr == ADDR_W'(W_STAT)) begin
      wr_data = (wdata & ~32'h1) | 32'h10;
    end else if (addr == ADDR_W'(W_ECC)) begin
      wr_data = (wdata | 32'h1000) & ~32'h2000;
    end
  end
endmodule

// File: rtl/dcfg_store.sv
module dcfg_store
  import dcfg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CTRL_WORDS = 64,
  parameter int PHY_BASE   = 256,
  parameter int PHY_WORDS  = 32,
  parameter logic [31:0] CONF_RST = 32'h3000_000E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_word
);
  localparam int CTRL_AW = $clog2(CTRL_WORDS);
  localparam int PHY_AW  = $clog2(PHY_WORDS);
  localparam logic [ADDR_W:0] CTRL_LIM = (ADDR_W+1)'(CTRL_WORDS);
  localparam logic [ADDR_W:0] PHY_LO   = (ADDR_W+1)'(PHY_BASE);
  localparam logic [ADDR_W:0] PHY_HI   = (ADDR_W+1)'(PHY_BASE + PHY_WORDS);

  logic [31:0] ctrl_q [CTRL_WORDS];
  logic [31:0] phy_q  [PHY_WORDS];

  logic [ADDR_W:0]    wa, ra;
  logic               wr_ctrl, wr_phy, rd_ctrl, rd_phy;
  logic [CTRL_AW-1:0] wr_cidx, rd_cidx;
  logic [PHY_AW-1:0]  wr_pidx, rd_pidx;

  always_comb begin
    wa      = {1'b0, wr_addr};
    ra      = {1'b0, rd_addr};
    wr_ctrl = wa < CTRL_LIM;
    rd_ctrl = ra < CTRL_LIM;
    wr_phy  = (wa >= PHY_LO) && (wa < PHY_HI);
    rd_phy  = (ra >= PHY_LO) && (ra < PHY_HI);
    wr_cidx = wr_addr[CTRL_AW-1:0];
    rd_cidx = rd_addr[CTRL_AW-1:0];
    wr_pidx = PHY_AW'(wa - PHY_LO);
    rd_pidx = PHY_AW'(ra - PHY_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CTRL_WORDS; i++) ctrl_q[i] <= (i == W_CONF) ? CONF_RST : 32'h0;
      for (int i = 0; i < PHY_WORDS; i++)  phy_q[i]  <= phy_reset(i);
    end else if (wr_en) begin
      if (wr_ctrl)     ctrl_q[wr_cidx] <= wr_data;
      else if (wr_phy) phy_q[wr_pidx]  <= wr_data;
    end
  end

  always_comb begin
    if (rd_ctrl)     rd_word = ctrl_q[rd_cidx];
    else if (rd_phy) rd_word = phy_q[rd_pidx];
    else             rd_word = 32'h0;
  end

  for (genvar g = 0; g < CTRL_WORDS; g++) begin : g_hold
    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_ctrl && wr_cidx == CTRL_AW'(g)) |=> $stable(ctrl_q[g])); // R4
  end

  AST_CONF_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[W_CONF][31:28] == 4'h3) && (ctrl_q[W_CONF][3:2] == 2'b11)); // R7
  AST_ECC_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ctrl && wr_cidx == CTRL_AW'(W_ECC)) |=> (ctrl_q[W_ECC][13:12] == 2'b01)); // R9
endmodule

// File: rtl/dcfg_regbank.sv
module dcfg_regbank
  import dcfg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int MEM_MIB    = 1024,
  parameter int CTRL_WORDS = 64,
  parameter int PHY_BASE   = 256,
  parameter int PHY_WORDS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              blk_err
);
  localparam logic [1:0]  SIZE_CODE = size_code(MEM_MIB);
  localparam logic [31:0] CONF_RST  = CONF_FIXED | {30'b0, SIZE_CODE};

  lock_e       state;
  logic [31:0] prot_rd, store_rd, wr_data;
  logic        wr_en, key_we, blocked;
  logic [31:0] rdata_q;
  logic        err_q;

  dcfg_lock u_lock (
    .clk(clk), .rst(rst), .key_we(key_we), .key_data(wdata),
    .state_o(state), .prot_rd(prot_rd)
  );

  dcfg_wfilter #(.ADDR_W(ADDR_W), .SIZE_CODE(SIZE_CODE)) u_filter (
    .req(req), .we(we), .be(be), .addr(addr), .wdata(wdata), .state(state),
    .wr_en(wr_en), .key_we(key_we), .wr_data(wr_data), .blocked(blocked)
  );

  dcfg_store #(
    .ADDR_W(ADDR_W), .CTRL_WORDS(CTRL_WORDS), .PHY_BASE(PHY_BASE),
    .PHY_WORDS(PHY_WORDS), .CONF_RST(CONF_RST)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_word(store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 32'h0;
      err_q   <= 1'b0;
    end else begin
      err_q <= blocked;
      if (req && !we) begin
        if (be != 4'hF)               rdata_q <= 32'h0;
        else if (addr == ADDR_W'(0))  rdata_q <= prot_rd;
        else                          rdata_q <= store_rd;
      end
    end
  end

  assign rdata   = rdata_q;
  assign blk_err = err_q;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    blk_err |-> $past(req && we && be == 4'hF)); // R11
endmodule

// File: tb/dcfg_regbank_bench.sv
module dcfg_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        blk_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dcfg_regbank u_dcfg_regbank (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .blk_err(blk_err)
  );

  function automatic logic [31:0] exp_reset(input int a);
    case (a)
      1:       return 32'h3000_000E;
      'h100:   return 32'h2;
      'h114:   return 32'h0FFF_FFFF;
      'h11A:   return 32'hFF;
      'h11F:   return 32'hFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exempt_w(input int a);
    return a == 'h14 || a == 'h1B || a == 'h1D || a == 'h1E ||
           a == 'h1F || a == 'h22 || a == 'h23 || a == 'h2D;
  endfunction

  function automatic bit implemented(input int a);
    return (a < 64) || (a >= 'h100 && a < 'h120);
  endfunction

  function automatic logic [31:0] stored(input int a, input logic [31:0] d);
    if (!implemented(a)) return 32'h0;
    if (a == 1)     return (d & 32'h0FF0_3FB0) | 32'h3000_000E;
    if (a == 'h18)  return (d & ~32'h1) | 32'h10;
    if (a == 'h1C)  return (d | 32'h1000) & ~32'h2000;
    return d;
  endfunction

  function automatic logic [31:0] pat(input int a, input logic [31:0] seed);
    return seed ^ (32'(a) * 32'h0001_0203);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input logic [31:0] d, input logic [3:0] b, output logic e);
    @(negedge clk);
    req = 1; we = 1; addr = 10'(a); wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = 4'hF;
    e = blk_err;
  endtask

  task automatic do_rd(input int a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = 10'(a); be = b;
    @(negedge clk);
    req = 0; be = 4'hF;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset image, R10: unimplemented words read 0
    check("R1 blk_err idle", 32'(blk_err), 0);
    for (int a = 0; a < 1024; a++) begin
      do_rd(a, 4'hF, d);
      check($sformatf("R1 reset word %h", a), d, exp_reset(a));
    end

    // R4 / R6 / R11: soft-closed sweep
    for (int a = 1; a < 1024; a++) begin
      do_wr(a, pat(a, 32'hC3C3_0000), 4'hF, e);
      check($sformatf("R11 soft err word %h", a), 32'(e), exempt_w(a) ? 0 : 1);
    end
    for (int a = 1; a < 1024; a++) begin
      do_rd(a, 4'hF, d);
      check($sformatf("R4 R6 soft word %h", a), d,
            exempt_w(a) ? pat(a, 32'hC3C3_0000) : exp_reset(a));
    end

    // R3: other value keeps soft lock; R4: lock word still writable
    do_wr(0, 32'h1234_5678, 4'hF, e);
    check("R4 lock word writable when soft", 32'(e), 0);
    do_rd(0, 4'hF, d);
    check("R3 other value soft", d, 32'h0);

    // R2: open
    do_wr(0, 32'hFC60_0309, 4'hF, e);
    check("R2 open no err", 32'(e), 0);
    do_rd(0, 4'hF, d);
    check("R2 open reads 1", d, 32'h1);

    // R7 R8 R9 R10: open sweep
    for (int a = 1; a < 1024; a++) begin
      do_wr(a, pat(a, 32'h5AA5_F00F), 4'hF, e);
      check($sformatf("R11 open err word %h", a), 32'(e), 0);
      do_rd(a, 4'hF, d);
      check($sformatf("R7 R8 R9 R10 open word %h", a), d,
            implemented(a) ? stored(a, pat(a, 32'h5AA5_F00F)) : 32'h0);
    end

    // Edge patterns on forced words
    do_wr(1, 32'hFFFF_FFFF, 4'hF, e); do_rd(1, 4'hF, d); check("R7 conf ones", d, 32'h3FF0_3FBE);
    do_wr(1, 32'h0, 4'hF, e);         do_rd(1, 4'hF, d); check("R7 conf zero", d, 32'h3000_000E);
    do_wr('h18, 32'hFFFF_FFFF, 4'hF, e); do_rd('h18, 4'hF, d); check("R8 stat ones", d, 32'hFFFF_FFFE);
    do_wr('h18, 32'h0, 4'hF, e);         do_rd('h18, 4'hF, d); check("R8 stat zero", d, 32'h10);
    do_wr('h1C, 32'hFFFF_FFFF, 4'hF, e); do_rd('h1C, 4'hF, d); check("R9 ecc ones", d, 32'hFFFF_DFFF);
    do_wr('h1C, 32'h0, 4'hF, e);         do_rd('h1C, 4'hF, d); check("R9 ecc zero", d, 32'h1000);

    // R10: partial accesses
    do_wr(2, 32'hDEAD_0000, 4'h3, e);
    check("R10 partial write no err", 32'(e), 0);
    do_rd(2, 4'h1, d); check("R10 partial read zero", d, 32'h0);
    do_rd(2, 4'hF, d); check("R10 partial write ignored", d, pat(2, 32'h5AA5_F00F));

    // R12: read latency
    @(negedge clk);
    req = 1; we = 0; addr = 10'd1; be = 4'hF;
    #5 check("R12 rdata before edge", rdata, pat(2, 32'h5AA5_F00F));
    @(negedge clk);
    req = 0;
    check("R12 rdata after edge", rdata, 32'h3000_000E);
    @(negedge clk);
    check("R12 rdata holds", rdata, 32'h3000_000E);

    // R3 / R4: close with other value, guarded write dropped
    do_wr(0, 32'h0000_0001, 4'hF, e);
    do_rd(0, 4'hF, d); check("R3 close reads 0", d, 32'h0);
    do_wr(3, 32'h1111_2222, 4'hF, e);
    check("R11 soft block err", 32'(e), 1);
    do_rd(3, 4'hF, d); check("R4 soft drop", d, pat(3, 32'h5AA5_F00F));

    // R3 / R5: seal, then immediate open attempt
    do_wr(0, 32'hFC60_0309, 4'hF, e);
    do_wr(0, 32'hDEAD_DEAD, 4'hF, e);
    check("R3 seal no err", 32'(e), 0);
    do_wr(0, 32'hFC60_0309, 4'hF, e);
    check("R11 sealed key err", 32'(e), 1);
    do_rd(0, 4'hF, d); check("R5 still sealed", d, 32'h10);
    do_wr(0, 32'h0, 4'hF, e);
    do_rd(0, 4'hF, d); check("R5 sealed ignores other", d, 32'h10);
    do_wr(2, 32'h7777_7777, 4'hF, e);
    check("R11 sealed guarded err", 32'(e), 1);
    do_rd(2, 4'hF, d); check("R5 sealed drop", d, pat(2, 32'h5AA5_F00F));
    do_wr('h22, 32'hABCD_1234, 4'hF, e);
    check("R6 sealed exempt no err", 32'(e), 0);
    do_rd('h22, 4'hF, d); check("R6 sealed exempt write", d, 32'hABCD_1234);

    // R1: reset coincident with a write
    @(negedge clk);
    rst = 1; req = 1; we = 1; addr = 10'd2; wdata = 32'h9999_9999; be = 4'hF;
    @(negedge clk);
    rst = 0; req = 0; we = 0;
    do_rd(2, 4'hF, d); check("R1 reset beats write", d, 32'h0);
    do_rd(0, 4'hF, d); check("R1 reset clears seal", d, 32'h0);
    do_rd(1, 4'hF, d); check("R1 reset conf", d, 32'h3000_000E);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule